// File: doc/BRIEF.md
# Staged Escalating Watchdog Timer

This block watches for a hung system and recovers it in up to four escalating steps. A single counter measures clock cycles spent in the current stage. When the count reaches that stage's timeout, the stage's configured action is taken: nothing, a level interrupt, a one-cycle core-reset pulse or a one-cycle system-reset pulse. The counter then restarts in the next enabled stage, and disabled stages are skipped. Software keeps the system alive by writing the feed address. A feed clears the counter and sends the block back to its first enabled stage.

Configuration is held behind a write lock. Control and timeout writes only take effect after a fixed 32-bit key has been written to the key address. Writing any other value to that address locks the registers again. Out of reset the watchdog is already running, with only stage 0 enabled, a system-reset action and a parameterised timeout. This protects the boot phase even if software never touches the block. Feeding and interrupt clearing are always allowed, whether the registers are locked or not.

The register port is a plain write strobe with address and data, plus a read address whose data comes back registered one cycle later.

Top module: `staged_wdt`

## Requirements
- R1: After reset the global enable is on and only stage 0 is enabled. Stage 0 has the system-reset action and timeout BOOT_TMO. Stages 1 to 3 have timeout 0xFFFFFFFF and the action none. The registers are locked, and irq_o, core_rst_o and sys_rst_o are low.
- R2: If nothing is written after reset, sys_rst_o pulses exactly once, on the (BOOT_TMO+1)th clock edge after reset is released.
- R3: While the registers are locked, writes to the control register (address 0) and to the timeout registers (addresses 1 to 4) leave them unchanged.
- R4: Writing KEY to address 6 unlocks the registers, and writing any other value to address 6 locks them. Reading address 6 returns 1 in bit 0 while the registers are locked and 0 while they are unlocked.
- R5: A write of any data to address 5 (feed) clears the counter and restarts at the lowest-numbered enabled stage. A feed works while the registers are locked, and a feed on the same edge as an expiry suppresses that expiry's action.
- R6: When the active stage's count reaches its timeout, that stage's action is taken and the counter clears. The next higher-numbered enabled stage becomes active, and disabled stages are skipped.
- R7: When no higher-numbered stage is enabled, the block goes idle. The counter holds 0 and no action occurs until a feed. Reading address 7 returns the active flag in bit 2 (0 when idle) and the stage number in bits [1:0].
- R8: The action of stage s is the 2-bit field at control bits [9+2s:8+2s]. The codes are 0 none, 1 interrupt, 2 core reset and 3 system reset. Each expiry with a reset action raises the matching reset output for exactly one cycle, and expiries with timeout 0 give pulses on consecutive cycles.
- R9: irq_o is a level. Writing address 7 with bit 0 = 1 clears it, and writing it with bit 0 = 0 has no effect. A new interrupt expiry on the same edge as a clear wins.
- R10: While control bit 0 (global enable) is 0, the counter holds 0 and no action occurs. Reading address 5 then returns 0.
- R11: A stage with timeout T expires on the (T+1)th clock edge after the edge on which it became active.
- R12: The register map is as follows. Address 0 is control: bit 0 is the global enable, bits [4:1] are the stage enables and bits [15:8] are the actions. Addresses 1 to 4 are the stage 0 to 3 timeouts, and address 5 reads the counter. rd_data_o presents the register selected by rd_addr_i one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | DW | Registered read data |
| irq_o | output | 1 | Interrupt level |
| core_rst_o | output | 1 | Core reset request pulse |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
A wrong stage number or a missed skip shows up as the wrong action on the wrong output. It appears at the first expiry after the fault, within one stage timeout plus one cycle. A corrupted counter shifts every pulse edge and is visible at the counter read address the cycle after it is selected. A lock that fails to hold, or fails to release, shows up in the read-back of control and timeout values one cycle after the read. The bench compares every output against a behavioural model on each clock, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/staged_wdt_pkg.sv
package staged_wdt_pkg;
  localparam int ADR_W = 3;

  localparam logic [ADR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADR_W-1:0] A_TMO0 = 3'd1;
  localparam logic [ADR_W-1:0] A_FEED = 3'd5;
  localparam logic [ADR_W-1:0] A_KEY  = 3'd6;
  localparam logic [ADR_W-1:0] A_STAT = 3'd7;

  localparam int CTRL_SEN_LSB = 1;
  localparam int CTRL_ACT_LSB = 8;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CORE = 2'd2,
    ACT_SYS  = 2'd3
  } wdt_act_e;
endpackage

// File: rtl/staged_wdt_regs.sv
module staged_wdt_regs
  import staged_wdt_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          NSTG     = 4,
  parameter logic [31:0] BOOT_TMO = 32'd1000,
  parameter logic [31:0] KEY      = 32'h6B3D_19A7
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic                          wr_en_i,
  input  logic [ADR_W-1:0]              wr_addr_i,
  input  logic [DW-1:0]                 wr_data_i,
  input  logic [ADR_W-1:0]              rd_addr_i,
  input  logic [DW-1:0]                 cnt_i,
  input  logic [$clog2(NSTG)-1:0]       stage_i,
  input  logic                          active_i,
  output logic [DW-1:0]                 rd_data_o,
  output logic                          en_o,
  output logic [NSTG-1:0]               sen_o,
  output logic [NSTG-1:0][1:0]          act_o,
  output logic [NSTG-1:0][DW-1:0]       tmo_o,
  output logic                          feed_o,
  output logic                          irq_clr_o,
  output logic                          locked_o
);
  localparam int SW = $clog2(NSTG);

  logic                    locked_q;
  logic                    en_q;
  logic [NSTG-1:0]         sen_q;
  logic [NSTG-1:0][1:0]    act_q;
  logic [NSTG-1:0][DW-1:0] tmo_q;
  logic [DW-1:0]           rd_nxt, rd_q;
  logic                    wr_cfg, wr_ctrl;

  assign wr_cfg    = wr_en_i && !locked_q;
  assign wr_ctrl   = wr_cfg && (wr_addr_i == A_CTRL);
  assign feed_o    = wr_en_i && (wr_addr_i == A_FEED);
  assign irq_clr_o = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      locked_q <= 1'b1;
    end else if (wr_en_i && (wr_addr_i == A_KEY)) begin
      locked_q <= (wr_data_i != DW'(KEY));
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q <= 1'b1;
    end else if (wr_ctrl) begin
      en_q <= wr_data_i[0];
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        sen_q[s] <= (s == 0);
        act_q[s] <= (s == 0) ? ACT_SYS : ACT_NONE;
        tmo_q[s] <= (s == 0) ? DW'(BOOT_TMO) : {DW{1'b1}};
      end else begin
        if (wr_ctrl) begin
          sen_q[s] <= wr_data_i[CTRL_SEN_LSB + s];
          act_q[s] <= wr_data_i[CTRL_ACT_LSB + 2*s +: 2];
        end
        if (wr_cfg && (wr_addr_i == ADR_W'(int'(A_TMO0) + s))) begin
          tmo_q[s] <= wr_data_i;
        end
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (rd_addr_i)
      A_CTRL: begin
        rd_nxt[0] = en_q;
        rd_nxt[CTRL_SEN_LSB +: NSTG] = sen_q;
        for (int s = 0; s < NSTG; s++) rd_nxt[CTRL_ACT_LSB + 2*s +: 2] = act_q[s];
      end
      A_FEED:  rd_nxt = cnt_i;
      A_KEY:   rd_nxt[0] = locked_q;
      A_STAT:  rd_nxt[SW:0] = {active_i, stage_i};
      default: begin
        for (int s = 0; s < NSTG; s++)
          if (rd_addr_i == ADR_W'(int'(A_TMO0) + s)) rd_nxt = tmo_q[s];
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_q <= '0;
    else       rd_q <= rd_nxt;
  end

  assign rd_data_o = rd_q;
  assign en_o      = en_q;
  assign sen_o     = sen_q;
  assign act_o     = act_q;
  assign tmo_o     = tmo_q;
  assign locked_o  = locked_q;
endmodule

// File: rtl/staged_wdt_seq.sv
module staged_wdt_seq #(
  parameter int DW   = 32,
  parameter int NSTG = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic                          en_i,
  input  logic [NSTG-1:0]               sen_i,
  input  logic [NSTG-1:0][1:0]          act_i,
  input  logic [NSTG-1:0][DW-1:0]       tmo_i,
  input  logic                          feed_i,
  output logic [DW-1:0]                 cnt_o,
  output logic [$clog2(NSTG)-1:0]       stage_o,
  output logic                          active_o,
  output logic                          fire_o,
  output logic [1:0]                    fire_act_o
);
  localparam int SW = $clog2(NSTG);

  logic [DW-1:0] cnt_q;
  logic [SW-1:0] stage_q, first_idx, next_idx;
  logic          active_q, first_ok, next_ok, hit;

  always_comb begin
    first_ok  = 1'b0;
    first_idx = '0;
    next_ok   = 1'b0;
    next_idx  = '0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (sen_i[i]) begin
        first_ok  = 1'b1;
        first_idx = SW'(i);
      end
      if (sen_i[i] && (i > int'(stage_q))) begin
        next_ok  = 1'b1;
        next_idx = SW'(i);
      end
    end
  end

  assign hit        = active_q && (cnt_q >= tmo_i[stage_q]);
  assign fire_o     = en_i && !feed_i && hit;
  assign fire_act_o = act_i[stage_q];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= '0;
      stage_q  <= '0;
      active_q <= 1'b1;
    end else if (!en_i || feed_i) begin
      cnt_q    <= '0;
      stage_q  <= first_idx;
      active_q <= first_ok;
    end else if (hit) begin
      cnt_q    <= '0;
      stage_q  <= next_ok ? next_idx : stage_q;
      active_q <= next_ok;
    end else if (active_q) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign stage_o  = stage_q;
  assign active_o = active_q;
endmodule

// File: rtl/staged_wdt_out.sv
module staged_wdt_out
  import staged_wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       fire_i,
  input  logic [1:0] fire_act_i,
  input  logic       irq_clr_i,
  output logic       irq_o,
  output logic       core_rst_o,
  output logic       sys_rst_o
);
  logic irq_q, core_q, sys_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_q  <= 1'b0;
      core_q <= 1'b0;
      sys_q  <= 1'b0;
    end else begin
      core_q <= fire_i && (fire_act_i == ACT_CORE);
      sys_q  <= fire_i && (fire_act_i == ACT_SYS);
      if (fire_i && (fire_act_i == ACT_IRQ)) irq_q <= 1'b1;
      else if (irq_clr_i)                    irq_q <= 1'b0;
    end
  end

  assign irq_o      = irq_q;
  assign core_rst_o = core_q;
  assign sys_rst_o  = sys_q;
endmodule

// File: rtl/staged_wdt.sv
module staged_wdt
  import staged_wdt_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          NSTG     = 4,
  parameter logic [31:0] BOOT_TMO = 32'd1000,
  parameter logic [31:0] KEY      = 32'h6B3D_19A7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [ADR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [ADR_W-1:0] rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             irq_o,
  output logic             core_rst_o,
  output logic             sys_rst_o
);
  localparam int SW = $clog2(NSTG);

  logic                    en_w, feed_w, irq_clr_w, locked_w, active_w, fire_w;
  logic [NSTG-1:0]         sen_w;
  logic [NSTG-1:0][1:0]    act_w;
  logic [NSTG-1:0][DW-1:0] tmo_w;
  logic [DW-1:0]           cnt_w;
  logic [SW-1:0]           stage_w;
  logic [1:0]              fire_act_w;

  staged_wdt_regs #(.DW(DW), .NSTG(NSTG), .BOOT_TMO(BOOT_TMO), .KEY(KEY)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .cnt_i(cnt_w), .stage_i(stage_w),
    .active_i(active_w), .rd_data_o(rd_data_o), .en_o(en_w), .sen_o(sen_w),
    .act_o(act_w), .tmo_o(tmo_w), .feed_o(feed_w), .irq_clr_o(irq_clr_w),
    .locked_o(locked_w)
  );

  staged_wdt_seq #(.DW(DW), .NSTG(NSTG)) u_seq (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_w), .sen_i(sen_w), .act_i(act_w),
    .tmo_i(tmo_w), .feed_i(feed_w), .cnt_o(cnt_w), .stage_o(stage_w),
    .active_o(active_w), .fire_o(fire_w), .fire_act_o(fire_act_w)
  );

  staged_wdt_out u_out (
    .clk_i(clk_i), .rst_i(rst_i), .fire_i(fire_w), .fire_act_i(fire_act_w),
    .irq_clr_i(irq_clr_w), .irq_o(irq_o), .core_rst_o(core_rst_o),
    .sys_rst_o(sys_rst_o)
  );
endmodule

// File: rtl/staged_wdt_chk.sv
module staged_wdt_chk
  import staged_wdt_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSTG = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_en_i,
  input logic [ADR_W-1:0] wr_addr_i,
  input logic             feed_i,
  input logic             irq_clr_i,
  input logic             en_i,
  input logic [NSTG-1:0]  sen_i,
  input logic             locked_i,
  input logic [DW-1:0]    cnt_i,
  input logic             irq_i,
  input logic             core_rst_i,
  input logic             sys_rst_i
);
  AST_NO_DUAL_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
    !(core_rst_i && sys_rst_i)); // R8

  AST_RESET_PULSE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    (core_rst_i || sys_rst_i) |-> (cnt_i == '0)); // R6

  AST_FEED_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    feed_i |=> (cnt_i == '0)); // R5

  AST_DISABLED_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (cnt_i == '0)); // R10

  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_i && !irq_clr_i) |=> irq_i); // R9

  AST_LOCKED_CFG_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    locked_i |=> ($stable(sen_i) && $stable(en_i))); // R3

  AST_LOCK_STICKS: assert property (@(posedge clk_i) disable iff (rst_i)
    (locked_i && !(wr_en_i && wr_addr_i == A_KEY)) |=> locked_i); // R4
endmodule

bind staged_wdt staged_wdt_chk #(.DW(DW), .NSTG(NSTG)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .feed_i(feed_w), .irq_clr_i(irq_clr_w), .en_i(en_w), .sen_i(sen_w),
  .locked_i(locked_w), .cnt_i(cnt_w), .irq_i(irq_o), .core_rst_i(core_rst_o),
  .sys_rst_i(sys_rst_o)
);

// File: tb/staged_wdt_test.sv
module staged_wdt_test;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BOOT       = 32'd40;
  localparam logic [31:0] KEYV       = 32'h6B3D_19A7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd7;
  logic [31:0] rd_data;
  logic        irq, core_rst, sys_rst;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string cur_req = "R1";

  staged_wdt #(.DW(32), .NSTG(4), .BOOT_TMO(BOOT), .KEY(KEYV)) uut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .core_rst_o(core_rst), .sys_rst_o(sys_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_tmo [4];
  int          m_act [4];
  bit          m_sen [4];
  bit          m_en, m_lock, m_active, m_irq, m_core, m_sys, m_valid = 0;
  logic [31:0] m_cnt, m_rd;
  int          m_stage;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 1; m_lock = 1; m_active = 1; m_irq = 0; m_core = 0; m_sys = 0;
      m_cnt = 0; m_rd = 0; m_stage = 0;
      for (int i = 0; i < 4; i++) begin
        m_sen[i] = (i == 0);
        m_act[i] = (i == 0) ? 3 : 0;
        m_tmo[i] = (i == 0) ? BOOT : 32'hFFFF_FFFF;
      end
    end else begin
      bit feed, clr, fire, nf;
      int fa, cs, ns;
      m_rd = 0;
      case (rd_addr)
        3'd0: begin
          m_rd[0] = m_en;
          for (int i = 0; i < 4; i++) begin
            m_rd[1+i] = m_sen[i];
            m_rd[8+2*i +: 2] = 2'(m_act[i]);
          end
        end
        3'd5: m_rd = m_cnt;
        3'd6: m_rd = {31'd0, m_lock};
        3'd7: m_rd = {29'd0, m_active, 2'(m_stage)};
        default: m_rd = m_tmo[int'(rd_addr) - 1];
      endcase
      feed = wr_en && wr_addr == 3'd5;
      clr  = wr_en && wr_addr == 3'd7 && wr_data[0];
      fire = 0; fa = 0;
      if (!m_en || feed) begin
        m_cnt = 0; m_stage = 0; m_active = 0;
        for (int i = 3; i >= 0; i--) if (m_sen[i]) begin m_active = 1; m_stage = i; end
      end else if (m_active && m_cnt >= m_tmo[m_stage]) begin
        fire = 1; fa = m_act[m_stage]; m_cnt = 0;
        cs = m_stage; nf = 0; ns = 0;
        for (int i = 3; i >= 0; i--) if (m_sen[i] && i > cs) begin nf = 1; ns = i; end
        if (nf) m_stage = ns;
        m_active = nf;
      end else if (m_active) begin
        m_cnt = m_cnt + 1;
      end
      m_core = fire && fa == 2;
      m_sys  = fire && fa == 3;
      if (fire && fa == 1) m_irq = 1;
      else if (clr)        m_irq = 0;
      if (wr_en) begin
        if (wr_addr == 3'd0 && !m_lock) begin
          m_en = wr_data[0];
          for (int i = 0; i < 4; i++) begin
            m_sen[i] = wr_data[1+i];
            m_act[i] = int'(wr_data[8+2*i +: 2]);
          end
        end else if (wr_addr >= 3'd1 && wr_addr <= 3'd4 && !m_lock) begin
          m_tmo[int'(wr_addr) - 1] = wr_data;
        end else if (wr_addr == 3'd6) begin
          m_lock = (wr_data != KEYV);
        end
      end
    end
    m_valid = 1;
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (m_valid) begin
      checks++;
      if (irq !== m_irq || core_rst !== m_core || sys_rst !== m_sys || rd_data !== m_rd) begin
        failures++;
        $display("FAIL %s cycle %0d: irq/core/sys/rd actual=%b/%b/%b/%h expected=%b/%b/%b/%h",
                 cur_req, cyc, irq, core_rst, sys_rst, rd_data, m_irq, m_core, m_sys, m_rd);
      end
    end
  end

  // pulse counters
  int n_sys = 0, n_core = 0, n_irq_rise = 0;
  bit irq_prev = 0;
  always @(posedge clk) begin
    #1;
    if (sys_rst) n_sys++;
    if (core_rst) n_core++;
    if (irq && !irq_prev) n_irq_rise++;
    irq_prev = irq;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
    rd_addr = 3'd7;
  endtask

  task automatic clr_counts();
    n_sys = 0; n_core = 0; n_irq_rise = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R12: reset state and register map
    cur_req = "R1";
    chk("R1 outputs low after reset", {29'd0, irq, core_rst, sys_rst}, 32'd0);
    rd_chk(3'd0, 32'h0000_0303, "R1 R12 ctrl reset value");
    rd_chk(3'd1, BOOT, "R1 stage0 timeout");
    rd_chk(3'd2, 32'hFFFF_FFFF, "R1 stage1 timeout");
    rd_chk(3'd6, 32'd1, "R1 locked after reset");

    // R2 / R7: boot protection fires once then idles
    cur_req = "R2";
    repeat (60) @(negedge clk);
    chk("R2 one system reset from boot protection", n_sys, 1);
    rd_chk(3'd7, 32'd0, "R7 idle after last stage");
    rd_chk(3'd5, 32'd0, "R7 counter held at zero while idle");

    // R3: locked writes ignored
    cur_req = "R3";
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd5);
    rd_chk(3'd0, 32'h0000_0303, "R3 ctrl unchanged while locked");
    rd_chk(3'd1, BOOT, "R3 timeout unchanged while locked");

    // R4: key unlock / relock
    cur_req = "R4";
    wr(3'd6, KEYV);
    rd_chk(3'd6, 32'd0, "R4 unlocked by key");
    wr(3'd2, 32'd7);
    rd_chk(3'd2, 32'd7, "R4 write accepted when unlocked");
    wr(3'd6, 32'd1234);
    rd_chk(3'd6, 32'd1, "R4 relocked by other value");
    wr(3'd2, 32'd9);
    rd_chk(3'd2, 32'd7, "R4 write ignored after relock");

    // R6 / R8: escalation with stage 1 disabled
    cur_req = "R6";
    wr(3'd6, KEYV);
    wr(3'd1, 32'd5);
    wr(3'd2, 32'd2);
    wr(3'd3, 32'd3);
    wr(3'd4, 32'd4);
    wr(3'd0, 32'h0000_E91B);
    clr_counts();
    wr(3'd5, 32'd0);
    repeat (30) @(negedge clk);
    chk("R6 R8 one interrupt", n_irq_rise, 1);
    chk("R6 disabled stage skipped (one core reset)", n_core, 1);
    chk("R8 one system reset", n_sys, 1);
    rd_chk(3'd7, 32'd3, "R7 idle in stage 3");

    // R9: interrupt clear
    cur_req = "R9";
    chk("R9 irq level held", {31'd0, irq}, 32'd1);
    wr(3'd7, 32'd0);
    chk("R9 clear with bit0=0 ignored", {31'd0, irq}, 32'd1);
    wr(3'd7, 32'd1);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);

    // R11: stage timing
    cur_req = "R11";
    wr(3'd5, 32'd0);
    begin
      int n = 0;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (irq && n == 0) n = k;
      end
      chk("R11 irq on (T+1)th edge", n, 6);
    end

    // R5: feeding while locked prevents any action
    cur_req = "R5";
    wr(3'd5, 32'd0);
    wr(3'd7, 32'd1);
    wr(3'd6, 32'd0);
    clr_counts();
    for (int k = 0; k < 15; k++) begin
      wr(3'd5, 32'hDEAD_BEEF);
      repeat (3) @(negedge clk);
    end
    chk("R5 no interrupt when fed while locked", n_irq_rise, 0);
    chk("R5 no resets when fed", n_core + n_sys, 0);

    // R10: global disable
    cur_req = "R10";
    wr(3'd6, KEYV);
    wr(3'd0, 32'h0000_E91A);
    clr_counts();
    repeat (40) @(negedge clk);
    chk("R10 no actions while disabled", n_irq_rise + n_core + n_sys, 0);
    rd_chk(3'd5, 32'd0, "R10 counter reads zero while disabled");

    // R8: back-to-back core resets with timeout 0
    cur_req = "R8";
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h0000_0A07);
    wr(3'd5, 32'd0);
    clr_counts();
    repeat (10) @(negedge clk);
    chk("R8 two consecutive core resets", n_core, 2);
    chk("R8 no system reset", n_sys, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule